// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes into asynchronous serial characters on a single output line. Bytes enter through a small write port that has a full flag and wait in a short queue. A shifter takes them out one at a time and sends each as a frame: a start bit, the data bits, an optional parity bit and one or two stop bits. An 8-bit mode word sets the character length, the parity type and the stop-bit count. The mode word is sampled when each character starts, so software may change it at any time without damaging a frame already on the line.

A 9-bit control word is written with a strobe. It can enable or disable the transmitter, raise or release a forced-low break condition, and reset the transmit path. The bit period comes from an external one-cycle tick. Every bit lasts from one tick to the next, so the surrounding logic sets the line rate without changing this block. Two status outputs show whether a character is shifting and whether anything is still waiting to go out.

The shifter is a state machine with six states. IDLE holds the line high. START drives the low start bit. DATA shifts the character out LSB first. PARITY drives the computed or forced parity bit. STOP drives one or two high stop bits. BREAK holds the line low. The transitions are as follows:
- IDLE→START on a tick when the transmitter is enabled, a byte is queued and no break is requested.
- IDLE→BREAK as soon as a break is requested.
- START→DATA on the next tick.
- DATA→PARITY or DATA→STOP on the tick that ends the last data bit.
- PARITY→STOP on a tick.
- STOP→STOP on the tick after the first of two stop bits.
- STOP→START, with no idle gap, when the load conditions hold at the end of the stop bits.
- STOP→IDLE at the end of the stop bits otherwise.
- BREAK→IDLE when the break is released.
- Any state goes to IDLE on a transmit reset.

Top module: `txu_frame_tx`

## Requirements
- R1: After reset the line is high, `tx_active` is 0, `tx_empty` is 1, `wr_full` is 0, the transmitter is disabled and no break is active.
- R2: A frame is one low start bit followed by the data bits, LSB first. Each bit lasts exactly one tick interval. Frames begin only on a tick, and the line idles high.
- R3: `mode_word[2:1]` sets the character length: 11 gives 6 bits, 10 gives 7 bits, and 00 or 01 gives 8 bits. For 6- and 7-bit characters the unused upper bits of the byte are ignored.
- R4: `mode_word[5:3]` sets the parity bit, which follows the data bits. 000 makes the count of ones in data plus parity even. 001 makes it odd. 010 always sends 0. 011 always sends 1. Any value with bit 5 set sends no parity bit.
- R5: `mode_word[7:6]` = 10 sends two stop bits. Any other value sends one.
- R6: A control write with bit 4 set enables the transmitter and one with bit 5 set disables it. When both are set, disable wins. While disabled, queued bytes wait. A character already shifting always completes.
- R7: A control write with bit 7 set requests a break and one with bit 8 set releases it; release wins if both are set. Once any character in flight has completed, the line is held low for as long as the break lasts, and queued bytes wait. After release the line returns high and transmission resumes.
- R8: A control write with bit 1 set empties the queue and returns the shifter to IDLE at once. The line is high on the following cycle.
- R9: `tx_active` is 1 exactly while a frame (start to stop) is on the line. `tx_empty` is 1 only when the queue holds nothing and no frame is shifting.
- R10: The queue holds FIFO_DEPTH bytes and sends them in write order. `wr_full` is 1 when it is full, and a write while full is dropped.
- R11: The mode word is captured when a character starts. Changing it during a frame does not alter that frame.
- R12: When the next byte is ready as the stop bits end, its start bit follows immediately, with no idle bit time in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Write strobe for the byte queue |
| wr_data | input | 8 | Byte to queue |
| wr_full | output | 1 | Queue is full; writes are dropped |
| mode_word | input | 8 | Framing mode (length, parity, stop bits) |
| ctrl_wr | input | 1 | Control word strobe |
| ctrl_word | input | 9 | Control bits: 1 reset, 4 enable, 5 disable, 7 break on, 8 break off |
| txd | output | 1 | Serial line output |
| tx_active | output | 1 | A frame is shifting |
| tx_empty | output | 1 | Nothing queued and nothing shifting |

## Verification
The bench decodes the line and checks every data, parity and stop bit against the mode. This catches a design that reverses bit order, keeps the upper bits of short characters, or inverts odd and even parity. Two stop bits are confirmed from the spacing between back-to-back start edges, because a lone trailing stop bit looks the same as idle. The same spacing check exposes a design that inserts an idle bit between queued frames. Other directed cases check each priority rule: a control write with both enable and disable set, a mode change in mid-frame, a break raised during a character, a reset in mid-frame, and a write to a full queue. A design with any of these wrong would send a stray frame, corrupt the frame in flight, cut a character short, or replay a dropped byte.

// File: rtl/txu_pkg.sv
package txu_pkg;
    localparam int DATA_W = 8;
    localparam int MODE_W = 8;
    localparam int CTRL_W = 9;
    localparam int CNT_W  = 4;

    // control word bit positions
    localparam int CTL_TXRST   = 1;
    localparam int CTL_EN      = 4;
    localparam int CTL_DIS     = 5;
    localparam int CTL_BRK_ON  = 7;
    localparam int CTL_BRK_OFF = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_BREAK
    } txu_state_e;

    typedef enum logic [1:0] {
        PK_EVEN, PK_ODD, PK_SPACE, PK_MARK
    } txu_par_e;

    typedef struct packed {
        logic [CNT_W-1:0] nbits;
        logic             par_en;
        txu_par_e         par_kind;
        logic             stop2;
    } txu_cfg_t;

    // decode framing fields; bit 0 of the mode word carries nothing here
    function automatic txu_cfg_t decode_mode(logic [MODE_W-1:1] m);
        txu_cfg_t c;
        c.nbits    = (m[2:1] == 2'b11) ? CNT_W'(6) :
                     (m[2:1] == 2'b10) ? CNT_W'(7) : CNT_W'(8);
        c.par_en   = !m[5];
        c.par_kind = txu_par_e'(m[4:3]);
        c.stop2    = (m[7:6] == 2'b10);
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] len_mask(logic [CNT_W-1:0] n);
        return {DATA_W{1'b1}} >> (CNT_W'(DATA_W) - n);
    endfunction

    function automatic logic parity_of(txu_cfg_t c, logic [DATA_W-1:0] d);
        logic p;
        unique case (c.par_kind)
            PK_EVEN:  p = ^d;
            PK_ODD:   p = ~^d;
            PK_SPACE: p = 1'b0;
            PK_MARK:  p = 1'b1;
            default:  p = 1'b0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/txu_ctl.sv
module txu_ctl
    import txu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              tx_en,
    output logic              brk_on,
    output logic              flush
);
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl_word[0], ctrl_word[3:2], ctrl_word[6]};

    assign flush = ctrl_wr && ctrl_word[CTL_TXRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en  <= 1'b0;
            brk_on <= 1'b0;
        end else if (ctrl_wr) begin
            if (ctrl_word[CTL_DIS])
                tx_en <= 1'b0;
            else if (ctrl_word[CTL_EN])
                tx_en <= 1'b1;
            if (ctrl_word[CTL_BRK_OFF])
                brk_on <= 1'b0;
            else if (ctrl_word[CTL_BRK_ON])
                brk_on <= 1'b1;
        end
    end

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_word[CTL_DIS] |=> !tx_en); // R6
    AST_BRK_RELEASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_word[CTL_BRK_OFF] |=> !brk_on); // R7
endmodule

// File: rtl/txu_fifo.sv
module txu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> full && $stable(wr_ptr)); // R10
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8
endmodule

// File: rtl/txu_shifter.sv
module txu_shifter
    import txu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              flush,
    input  logic              tx_en,
    input  logic              brk_on,
    input  logic              have_data,
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] din,
    output logic              pop,
    output logic              txd,
    output logic              active
);
    txu_state_e       state, nxt;
    txu_cfg_t         cfg, new_cfg;
    logic [DATA_W-1:0] shreg, new_data;
    logic [CNT_W-1:0] bitcnt;
    logic             par_bit, stop_second, load, can_load;
    logic             unused_mode_lsb;

    assign unused_mode_lsb = mode[0];
    assign new_cfg  = decode_mode(mode[MODE_W-1:1]);
    assign new_data = din & len_mask(new_cfg.nbits);
    assign can_load = tx_en && have_data && !brk_on;
    assign pop      = load;

    // next-state logic
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (brk_on)
                    nxt = ST_BREAK;
                else if (tick && can_load) begin
                    nxt  = ST_START;
                    load = 1'b1;
                end
            end
            ST_START:  if (tick) nxt = ST_DATA;
            ST_DATA:   if (tick && bitcnt == cfg.nbits - CNT_W'(1))
                           nxt = cfg.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick) nxt = ST_STOP;
            ST_STOP: begin
                if (tick) begin
                    if (cfg.stop2 && !stop_second)
                        nxt = ST_STOP;
                    else if (can_load) begin
                        nxt  = ST_START;
                        load = 1'b1;
                    end else
                        nxt = ST_IDLE;
                end
            end
            ST_BREAK:  if (!brk_on) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (flush) begin
            nxt  = ST_IDLE;
            load = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // character datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg         <= decode_mode('0);
            shreg       <= '0;
            par_bit     <= 1'b0;
            bitcnt      <= '0;
            stop_second <= 1'b0;
        end else begin
            if (load) begin
                cfg     <= new_cfg;
                shreg   <= new_data;
                par_bit <= parity_of(new_cfg, new_data);
            end else if (state == ST_DATA && tick) begin
                shreg <= shreg >> 1;
            end
            if (state != ST_DATA)  bitcnt <= '0;
            else if (tick)         bitcnt <= bitcnt + CNT_W'(1);
            if (state != ST_STOP)  stop_second <= 1'b0;
            else if (tick)         stop_second <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        txd    = 1'b1;
        active = 1'b0;
        unique case (state)
            ST_IDLE:   begin txd = 1'b1;     active = 1'b0; end
            ST_START:  begin txd = 1'b0;     active = 1'b1; end
            ST_DATA:   begin txd = shreg[0]; active = 1'b1; end
            ST_PARITY: begin txd = par_bit;  active = 1'b1; end
            ST_STOP:   begin txd = 1'b1;     active = 1'b1; end
            ST_BREAK:  begin txd = 1'b0;     active = 1'b0; end
            default:   begin txd = 1'b1;     active = 1'b0; end
        endcase
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_START |-> $stable(cfg)); // R11
    AST_FLUSH_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> state == ST_IDLE); // R8
    AST_FRAME_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(tick)); // R2
    AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BREAK && brk_on && !flush |=> state == ST_BREAK); // R7
endmodule

// File: rtl/txu_frame_tx.sv
module txu_frame_tx
    import txu_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              txd,
    output logic              tx_active,
    output logic              tx_empty
);
    logic              tx_en, brk_on, flush;
    logic              q_empty, q_pop;
    logic [DATA_W-1:0] q_data;

    txu_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_word (ctrl_word),
        .tx_en     (tx_en),
        .brk_on    (brk_on),
        .flush     (flush)
    );

    txu_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (q_pop),
        .dout  (q_data),
        .empty (q_empty),
        .full  (wr_full)
    );

    txu_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .flush     (flush),
        .tx_en     (tx_en),
        .brk_on    (brk_on),
        .have_data (!q_empty),
        .mode      (mode_word),
        .din       (q_data),
        .pop       (q_pop),
        .txd       (txd),
        .active    (tx_active)
    );

    assign tx_empty = q_empty && !tx_active;

    AST_EMPTY_MEANS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty && !wr_en |=> !tx_active); // R9
endmodule

// File: tb/txu_frame_tx_tb_top.sv
module txu_frame_tx_tb_top;
    localparam int DEPTH = 4;
    localparam int BIT_CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] mode_word = 8'h20;
    logic       ctrl_wr = 1'b0;
    logic [8:0] ctrl_word = '0;
    logic       wr_full, txd, tx_active, tx_empty;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tick_cnt = 0;
    int last_start = 0;

    localparam logic [8:0] C_RST = 9'h002, C_EN = 9'h010, C_DIS = 9'h020,
                           C_BOTH = 9'h030, C_BON = 9'h080, C_BOFF = 9'h100;

    always #2.5 clk = ~clk;

    txu_frame_tx #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .mode_word(mode_word), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
        .txd(txd), .tx_active(tx_active), .tx_empty(tx_empty)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        tick_cnt  <= (tick_cnt == BIT_CYC - 1) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == BIT_CYC - 1);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ctl(input logic [8:0] w);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_word = w;
        @(negedge clk); ctrl_wr = 1'b0; ctrl_word = '0;
    endtask

    // expected bits after the start bit, index 0 first on the line
    function automatic int exp_frame(input logic [7:0] d, input logic [7:0] m,
                                     output logic [11:0] bits);
        int nb, n;
        logic [7:0] dm;
        logic p;
        nb = (m[2:1] == 2'b11) ? 6 : (m[2:1] == 2'b10) ? 7 : 8;
        dm = d & ((8'd1 << nb) - 8'd1);
        if (nb == 8) dm = d;
        bits = '0;
        for (int i = 0; i < nb; i++) bits[i] = dm[i];
        n = nb;
        if (!m[5]) begin
            case (m[4:3])
                2'b00: p = ^dm;
                2'b01: p = ~^dm;
                2'b10: p = 1'b0;
                default: p = 1'b1;
            endcase
            bits[n] = p;
            n++;
        end
        bits[n] = 1'b1; n++;
        if (m[7:6] == 2'b10) begin bits[n] = 1'b1; n++; end
        return n;
    endfunction

    task automatic capture(input logic [7:0] d, input logic [7:0] m, input string req);
        logic [11:0] eb, got;
        int n, waited;
        bit ok;
        n = exp_frame(d, m, eb);
        waited = 0;
        got = '0;
        @(negedge clk);
        while (txd !== 1'b0 && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 400) begin
            chk(0, req, "no start bit seen", 1, 0);
            return;
        end
        last_start = cyc;
        repeat (BIT_CYC / 2) @(negedge clk);
        ok = (txd === 1'b0);
        for (int i = 0; i < n; i++) begin
            repeat (BIT_CYC) @(negedge clk);
            got[i] = txd;
        end
        chk(ok && (got == eb), req, $sformatf("frame of byte 0x%0h mode 0x%0h", d, m),
            int'(got), int'(eb));
    endtask

    task automatic quiet(input int n, input string req, input string what);
        int lows = 0;
        repeat (n) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk(lows == 0, req, what, lows, 0);
    endtask

    task automatic settle();
        int w = 0;
        while (!(tx_empty === 1'b1) && w < 2000) begin @(negedge clk); w++; end
        repeat (BIT_CYC * 2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
        chk(tx_active === 1'b0, "R1", "tx_active after reset", tx_active, 0);
        chk(tx_empty === 1'b1, "R1", "tx_empty after reset", tx_empty, 1);
        chk(wr_full === 1'b0, "R1", "wr_full after reset", wr_full, 0);
        push_byte(8'h3C);
        quiet(60, "R1", "line stays idle while disabled after reset");
        ctl(C_RST);
    endtask

    task automatic t_basic();
        mode_word = 8'h20;
        ctl(C_EN);
        push_byte(8'hA5);
        chk(tx_empty === 1'b0, "R9", "tx_empty with byte pending", tx_empty, 0);
        fork
            capture(8'hA5, 8'h20, "R2");
            begin
                repeat (BIT_CYC * 3) @(negedge clk);
                chk(tx_active === 1'b1, "R9", "tx_active mid frame", tx_active, 1);
            end
        join
        repeat (BIT_CYC) @(negedge clk);
        chk(tx_active === 1'b0, "R9", "tx_active after frame", tx_active, 0);
        chk(tx_empty === 1'b1, "R9", "tx_empty after frame", tx_empty, 1);
    endtask

    task automatic t_lengths();
        mode_word = 8'h24;   // 7 bits, no parity
        push_byte(8'hD3);
        capture(8'hD3, 8'h24, "R3");
        settle();
        mode_word = 8'h0E;   // 6 bits, odd parity
        push_byte(8'hF5);
        capture(8'hF5, 8'h0E, "R3");
        settle();
        mode_word = 8'h02;   // code 01 means 8 bits, even parity
        push_byte(8'h81);
        capture(8'h81, 8'h02, "R3");
        settle();
    endtask

    task automatic t_parity();
        logic [7:0] modes [5] = '{8'h00, 8'h08, 8'h10, 8'h18, 8'h38};
        for (int i = 0; i < 5; i++) begin
            mode_word = modes[i];
            push_byte(8'h6B);
            capture(8'h6B, modes[i], "R4");
            settle();
        end
    endtask

    task automatic t_stop_and_gap(input logic [7:0] m, input int bits, input string req);
        int s1;
        mode_word = m;
        ctl(C_DIS);
        push_byte(8'h11);
        push_byte(8'h22);
        ctl(C_EN);
        capture(8'h11, m, req);
        s1 = last_start;
        capture(8'h22, m, req);
        chk(last_start - s1 == bits * BIT_CYC, req, "start-to-start spacing",
            last_start - s1, bits * BIT_CYC);
        settle();
    endtask

    task automatic t_disable();
        mode_word = 8'h20;
        ctl(C_DIS);
        push_byte(8'h5A);
        quiet(60, "R6", "no frame while disabled");
        chk(tx_empty === 1'b0, "R9", "byte still pending while disabled", tx_empty, 0);
        ctl(C_BOTH);
        quiet(60, "R6", "enable and disable together keeps it off");
        ctl(C_EN);
        capture(8'h5A, 8'h20, "R6");
        settle();
        push_byte(8'hC3);
        fork
            capture(8'hC3, 8'h20, "R6");
            begin
                repeat (BIT_CYC * 4) @(negedge clk);
                ctl(C_DIS);
            end
        join
        settle();
        ctl(C_EN);
    endtask

    task automatic t_full();
        logic [7:0] d [DEPTH];
        mode_word = 8'h20;
        ctl(C_DIS);
        for (int i = 0; i < DEPTH; i++) begin
            d[i] = 8'(8'h30 + i * 7);
            push_byte(d[i]);
        end
        chk(wr_full === 1'b1, "R10", "wr_full after filling", wr_full, 1);
        push_byte(8'hEE);
        ctl(C_EN);
        for (int i = 0; i < DEPTH; i++) capture(d[i], 8'h20, "R10");
        quiet(120, "R10", "write to full queue was dropped");
        chk(tx_empty === 1'b1, "R10", "queue drained", tx_empty, 1);
    endtask

    task automatic t_break();
        int lows = 0;
        mode_word = 8'h20;
        push_byte(8'h96);
        fork
            capture(8'h96, 8'h20, "R7");
            begin
                repeat (BIT_CYC * 3) @(negedge clk);
                ctl(C_BON);
            end
        join
        repeat (BIT_CYC) @(negedge clk);
        push_byte(8'h4D);
        repeat (60) begin
            @(negedge clk);
            if (txd !== 1'b0) lows++;
        end
        chk(lows == 0, "R7", "line held low during break", lows, 0);
        chk(tx_empty === 1'b0, "R7", "byte waits during break", tx_empty, 0);
        ctl(C_BON | C_BOFF);
        @(negedge clk);
        chk(txd === 1'b1, "R7", "line high after break release", txd, 1);
        capture(8'h4D, 8'h20, "R7");
        settle();
    endtask

    task automatic t_txreset();
        mode_word = 8'h20;
        ctl(C_DIS);
        push_byte(8'h01);
        push_byte(8'h02);
        push_byte(8'h03);
        ctl(C_EN);
        while (txd !== 1'b0) @(negedge clk);
        repeat (BIT_CYC * 2 + 3) @(negedge clk);
        ctl(C_RST);
        chk(txd === 1'b1, "R8", "line high after tx reset", txd, 1);
        chk(tx_active === 1'b0, "R8", "inactive after tx reset", tx_active, 0);
        chk(tx_empty === 1'b1, "R8", "empty after tx reset", tx_empty, 1);
        quiet(150, "R8", "flushed bytes are not sent");
    endtask

    task automatic t_mode_latch();
        mode_word = 8'h20;
        push_byte(8'hB7);
        fork
            capture(8'hB7, 8'h20, "R11");
            begin
                repeat (BIT_CYC * 3) @(negedge clk);
                mode_word = 8'h0E;
            end
        join
        settle();
        push_byte(8'hB7);
        capture(8'hB7, 8'h0E, "R11");
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_basic();
        t_lengths();
        t_parity();
        t_stop_and_gap(8'hA0, 11, "R5");
        t_stop_and_gap(8'h20, 10, "R12");
        t_disable();
        t_full();
        t_break();
        t_txreset();
        ctl(C_EN);
        t_mode_latch();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule